// File: doc/BRIEF.md
# Period-Register PWM Generator

This block produces a free-running pulse-width-modulated output from a single clock. Each clock cycle is one input tick. A prescaler divides the tick by 1, 4 or 16. The prescaled tick advances an 8-bit timer that counts from zero up to a programmable terminal value and then restarts, so this terminal value sets the length of one PWM cycle. The high time is set by a 10-bit duty word. The duty word is compared against an extended count made of the timer with two prescaler stages below it. The high time is therefore four times finer than one timer step.

A separate postscaler counts completed timer cycles and raises a sticky interrupt flag after a programmed number of them. The postscaler only sets how often the flag fires and has no effect on the waveform. Terminal value, duty word and prescale select are sampled into working registers at the start of every PWM cycle. A change made in mid-cycle therefore appears only from the next cycle boundary and the waveform never glitches. There is no data stream here. All configuration pins are plain levels with no handshake and no back-pressure: the block reads them whenever it needs them, and the host keeps them steady for as long as it wants a setting to hold.

Top module: `pwm_period_gen`

## Requirements
- R1: While reset is asserted (rst_n low), pwm_o and irq_o are 0. The first rising clock edge after release starts a PWM cycle at timer count 0, using the configuration present on the pins at that edge.
- R2: Prescale select psc_sel_i encodes the divide ratio: 2'b00 = 1, 2'b01 = 4, 2'b10 or 2'b11 = 16. The timer advances once per ratio clocks.
- R3: One PWM cycle lasts (period_i + 1) × ratio clocks. The timer runs from 0 up to period_i and returns to 0 on the tick after it equals period_i.
- R4: pwm_o is high exactly while the 10-bit extended count {timer, f} is below the duty word. f is 2'b00 for ratio 1, prescaler bits [1:0] for ratio 4, and prescaler bits [3:2] for ratio 16. The high time per cycle is therefore min(L, ceil(duty/4)), min(L, duty) or min(L, 4×duty) clocks for the three ratios, where L is the cycle length.
- R5: A duty word of 0 keeps pwm_o low for the whole cycle.
- R6: A duty word at or above the full cycle length in extended-count units ((period_i+1)×4) keeps pwm_o high for the whole cycle.
- R7: period_i, duty_i and psc_sel_i are captured only at the start of a cycle. Changes during a cycle leave the current cycle unchanged.
- R8: With post_ratio_i = N−1 (N from 1 to 16), irq_o is set in the clock after every N-th cycle end.
- R9: irq_o stays set until irq_clr_i is high at a clock edge. When a set and a clear meet at the same edge, the set wins.
- R10: The waveform repeats every cycle with no further input: the next cycle starts high exactly when the duty word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge is one input tick |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 8 | Timer terminal value |
| duty_i | input | 10 | High-time word in extended-count units |
| psc_sel_i | input | 2 | Prescale ratio select |
| post_ratio_i | input | 4 | Cycle-end count per interrupt, minus one |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The assertions check these properties on every clock: the prescaler never passes its terminal count, the timer never passes the working terminal value and returns to zero after a wrap, the working registers hold between cycle boundaries, a zero duty word gives a low output, an oversized duty word gives a high output, and the interrupt flag rises only after a cycle end, with a set beating a clear. The bench scenarios are needed for the exact high time and cycle length under each prescale ratio, for a mid-cycle change that takes effect only at the next boundary, and for the number of cycle ends between interrupts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Prescaler depth covers the largest ratio (16).
  localparam int PSC_W  = 4;
  // Prescaler stages added below the timer for duty resolution.
  localparam int FRAC_W = 2;

  typedef enum logic [1:0] {
    PSC_DIV1  = 2'b00,
    PSC_DIV4  = 2'b01,
    PSC_DIV16 = 2'b10
  } psc_sel_e;

  // Terminal prescaler count for a given ratio.
  function automatic logic [PSC_W-1:0] psc_last(input psc_sel_e s);
    case (s)
      PSC_DIV1: psc_last = PSC_W'(0);
      PSC_DIV4: psc_last = PSC_W'(3);
      default:  psc_last = PSC_W'(15);
    endcase
  endfunction

  // The two prescaler bits that extend the timer for duty comparison.
  function automatic logic [FRAC_W-1:0] psc_frac(input psc_sel_e s,
                                                 input logic [PSC_W-1:0] c);
    case (s)
      PSC_DIV1: psc_frac = '0;
      PSC_DIV4: psc_frac = c[1:0];
      default:  psc_frac = c[3:2];
    endcase
  endfunction
endpackage

// File: rtl/pwm_cfg_latch.sv
module pwm_cfg_latch
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  psc_sel_e          sel_i,
  output logic              armed_o,
  output logic              load_o,
  output logic [TMR_W-1:0]  per_act_o,
  output logic [DUTY_W-1:0] duty_act_o,
  output psc_sel_e          sel_act_o,
  output logic [DUTY_W-1:0] duty_nxt_o,
  output psc_sel_e          sel_nxt_o
);
  // A cycle starts on the first edge after reset and on every wrap.
  assign load_o     = !armed_o || wrap_i;
  assign duty_nxt_o = load_o ? duty_i : duty_act_o;
  assign sel_nxt_o  = load_o ? sel_i  : sel_act_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_o    <= 1'b0;
      per_act_o  <= '0;
      duty_act_o <= '0;
      sel_act_o  <= PSC_DIV1;
    end else begin
      armed_o <= 1'b1;
      if (load_o) begin
        per_act_o  <= period_i;
        duty_act_o <= duty_i;
        sel_act_o  <= sel_i;
      end
    end
  end

  assert_hold_between_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |=> ($stable(per_act_o) && $stable(duty_act_o) && $stable(sel_act_o)));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  psc_sel_e         sel_act_i,
  input  psc_sel_e         sel_nxt_i,
  output logic             tick_o,
  output logic [FRAC_W-1:0] frac_nxt_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] cnt_d;
  logic [PSC_W-1:0] last;

  assign last   = psc_last(sel_act_i);
  assign tick_o = (cnt_q >= last);

  always_comb begin
    if (load_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + PSC_W'(1);
  end

  assign frac_nxt_o = psc_frac(sel_nxt_i, cnt_d);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_presc_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] per_act_i,
  output logic             wrap_o,
  output logic [TMR_W-1:0] timer_nxt_o
);
  logic [TMR_W-1:0] timer_q;

  assign wrap_o = armed_i && tick_i && (timer_q == per_act_i);

  always_comb begin
    if (load_i)      timer_nxt_o = '0;
    else if (tick_i) timer_nxt_o = timer_q + TMR_W'(1);
    else             timer_nxt_o = timer_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) timer_q <= '0;
    else        timer_q <= timer_nxt_o;
  end

  assert_timer_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timer_q <= per_act_i);
  assert_restart_after_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (timer_q == '0));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  localparam int EXT_W = TMR_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] timer_nxt_i,
  input  logic [FRAC_W-1:0] frac_nxt_i,
  input  logic [EXT_W-1:0] duty_nxt_i,
  input  logic [EXT_W-1:0] duty_act_i,
  input  logic [TMR_W-1:0] per_act_i,
  output logic             pwm_o
);
  logic [EXT_W-1:0] ext_nxt;
  logic [EXT_W:0]   full_len;

  // Output is registered from next-state count so it lines up with the timer.
  assign ext_nxt  = {timer_nxt_i, frac_nxt_i};
  assign full_len = {1'b0, per_act_i, FRAC_W'(0)} + (EXT_W + 1)'(1 << FRAC_W);

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= (ext_nxt < duty_nxt_i);
  end

  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act_i == '0) |-> !pwm_o);
  assert_full_duty_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, duty_act_i} >= full_len) |-> pwm_o);
endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_i,
  input  logic [POST_W-1:0] ratio_i,
  input  logic              clr_i,
  output logic              irq_o
);
  logic [POST_W-1:0] cnt_q;
  logic              hit;

  assign hit = wrap_i && (cnt_q >= ratio_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      if (wrap_i) cnt_q <= (cnt_q >= ratio_i) ? '0 : cnt_q + POST_W'(1);
      if (hit)        irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
    end
  end

  assert_irq_after_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(wrap_i));
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_i) |=> irq_o);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o);
endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen
  import pwm_pkg::*;
#(
  parameter int  TMR_W  = 8,
  parameter int  POST_W = 4,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [1:0]        psc_sel_i,
  input  logic [POST_W-1:0] post_ratio_i,
  input  logic              irq_clr_i,
  output logic              pwm_o,
  output logic              irq_o
);
  logic              armed, load, wrap, tick;
  logic [TMR_W-1:0]  per_act, timer_nxt;
  logic [DUTY_W-1:0] duty_act, duty_nxt;
  logic [FRAC_W-1:0] frac_nxt;
  psc_sel_e          sel_act, sel_nxt;

  pwm_cfg_latch #(.TMR_W(TMR_W), .DUTY_W(DUTY_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap),
    .period_i(period_i), .duty_i(duty_i), .sel_i(psc_sel_e'(psc_sel_i)),
    .armed_o(armed), .load_o(load), .per_act_o(per_act),
    .duty_act_o(duty_act), .sel_act_o(sel_act),
    .duty_nxt_o(duty_nxt), .sel_nxt_o(sel_nxt)
  );

  pwm_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .sel_act_i(sel_act), .sel_nxt_i(sel_nxt),
    .tick_o(tick), .frac_nxt_o(frac_nxt)
  );

  pwm_timebase #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .armed_i(armed), .load_i(load),
    .tick_i(tick), .per_act_i(per_act),
    .wrap_o(wrap), .timer_nxt_o(timer_nxt)
  );

  pwm_compare #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .timer_nxt_i(timer_nxt), .frac_nxt_i(frac_nxt),
    .duty_nxt_i(duty_nxt), .duty_act_i(duty_act), .per_act_i(per_act),
    .pwm_o(pwm_o)
  );

  pwm_postscaler #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .ratio_i(post_ratio_i),
    .clr_i(irq_clr_i), .irq_o(irq_o)
  );
endmodule

// File: tb/tb_pwm_period_gen.sv
module tb_pwm_period_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] period_i = '0;
  logic [9:0] duty_i = '0;
  logic [1:0] psc_sel_i = '0;
  logic [3:0] post_ratio_i = '0;
  logic       irq_clr_i = 1'b0;
  logic       pwm_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_period_gen dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .psc_sel_i(psc_sel_i), .post_ratio_i(post_ratio_i), .irq_clr_i(irq_clr_i),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [7:0]  per;
    logic [9:0]  duty;
    logic [1:0]  sel;
    logic [15:0] high;
    logic [15:0] len;
  } vec_t;

  // period, duty, select, expected high clocks, expected cycle length
  localparam vec_t VECS [8] = '{
    '{8'd9,   10'd20,   2'b00, 16'd5,    16'd10},
    '{8'd9,   10'd0,    2'b00, 16'd0,    16'd10},
    '{8'd3,   10'd7,    2'b01, 16'd7,    16'd16},
    '{8'd3,   10'd16,   2'b01, 16'd16,   16'd16},
    '{8'd2,   10'd5,    2'b10, 16'd20,   16'd48},
    '{8'd7,   10'd1023, 2'b11, 16'd128,  16'd128},
    '{8'd1,   10'd3,    2'b00, 16'd1,    16'd2},
    '{8'd248, 10'd500,  2'b10, 16'd2000, 16'd3984}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Leaves the bench sampling cycle 0 of the first PWM cycle.
  task automatic restart();
    rst_n = 1'b0;
    repeat (2) step();
    check("R1 pwm in reset", int'(pwm_o), 0);
    check("R1 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    int hi;
    int irq_early;
    // Vector walk: R2 R3 R4 R5 R6 R10
    foreach (VECS[i]) begin
      period_i = VECS[i].per; duty_i = VECS[i].duty; psc_sel_i = VECS[i].sel;
      post_ratio_i = 4'd0; irq_clr_i = 1'b0;
      restart();
      hi = 0; irq_early = 0;
      for (int c = 0; c < int'(VECS[i].len); c++) begin
        hi += int'(pwm_o);
        irq_early += int'(irq_o);
        step();
      end
      check($sformatf("R4 high clocks vec%0d", i), hi, int'(VECS[i].high));
      check($sformatf("R3 no early cycle end vec%0d", i), irq_early, 0);
      check($sformatf("R3 cycle end at length vec%0d", i), int'(irq_o), 1);
      check($sformatf("R10 next cycle start vec%0d", i), int'(pwm_o),
            int'(VECS[i].duty != 0));
    end

    // R7: mid-cycle changes wait for the boundary
    period_i = 8'd3; duty_i = 10'd8; psc_sel_i = 2'b01; post_ratio_i = 4'd0;
    restart();
    hi = 0; irq_early = 0;
    for (int c = 0; c < 16; c++) begin
      hi += int'(pwm_o);
      irq_early += int'(irq_o);
      if (c == 5) begin
        period_i = 8'd1; duty_i = 10'd2; psc_sel_i = 2'b00;
      end
      step();
    end
    check("R7 old duty kept", hi, 8);
    check("R7 old length kept", irq_early, 0);
    check("R7 old length end", int'(irq_o), 1);
    hi = int'(pwm_o);
    irq_clr_i = 1'b1;
    step();
    irq_clr_i = 1'b0;
    check("R9 clear works", int'(irq_o), 0);
    hi += int'(pwm_o);
    step();
    check("R7 new duty applied", hi, 1);
    check("R7 new length applied", int'(irq_o), 1);

    // R8: divide-by-3 postscaler
    period_i = 8'd1; duty_i = 10'd4; psc_sel_i = 2'b00; post_ratio_i = 4'd2;
    restart();
    irq_early = 0;
    for (int c = 0; c < 6; c++) begin
      irq_early += int'(irq_o);
      step();
    end
    check("R8 no irq before third end", irq_early, 0);
    check("R8 irq after third end", int'(irq_o), 1);
    repeat (4) step();
    check("R9 flag sticky", int'(irq_o), 1);

    // R9: set beats clear
    post_ratio_i = 4'd0;
    restart();
    irq_clr_i = 1'b1;
    step();
    step();
    check("R9 set wins over clear", int'(irq_o), 1);
    step();
    check("R9 clear next edge", int'(irq_o), 0);
    irq_clr_i = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule